// File: doc/BRIEF.md
# Time-Sliced Shared-RAM Arbiter

This block lets a 16-bit CPU with an asynchronous, strobe-and-acknowledge bus share one RAM with a video fetch unit without any request/grant exchange. A free-running slot counter splits every eight clocks into two halves. The CPU owns the RAM during slots 0 to 3 and the video unit owns it during slots 4 to 7. The counter's top bit is the turn bit. It selects the RAM address source, gates the CPU data transceiver and qualifies RAM write-enable.

The CPU never sees a conflict. A RAM access made outside its window is held off because the active-low acknowledge stays high until the next CPU window reaches slot 2. A non-RAM access is acknowledged as soon as its strobes are valid. The acknowledge logic remembers whether acknowledge was given on the previous clock. Because of this, a RAM access whose strobes first appear at slot 3 is not acknowledged late in the window. Every acknowledged RAM cycle therefore completes at the end of slot 3, and a CPU that starts out of phase falls back into step after one stalled access.

Top module: `tsram_arbiter`

## Requirements
- R1: After synchronous reset the slot counter is 0. It increments by one on every clock and wraps from 7 to 0. `vid_turn` is 0 in slots 0-3 and 1 in slots 4-7.
- R2: `ram_addr` equals `cpu_addr` when `vid_turn` is 0 and equals `vid_addr` when `vid_turn` is 1.
- R3: An access is valid when `as_n` is 0 and at least one of `uds_n` and `lds_n` is 0. When `ram_sel_n` is 1, `dtack_n` equals the inverse of that valid term in every slot.
- R4: A valid access with `ram_sel_n` at 0 gets `dtack_n` at 0 in slot 2.
- R5: In slot 3, a valid RAM access gets `dtack_n` at 0 only if `dtack_n` was 0 in the clock just before.
- R6: In slots 0, 1 and 4-7, `dtack_n` is 1 whenever `ram_sel_n` is 0.
- R7: With no valid access, `dtack_n` is 1 in every slot.
- R8: `xcvr_en_n` is 0 exactly when `vid_turn` is 0 and `ram_sel_n` is 0. `xcvr_dir` follows `rw` (1 = read, RAM drives the CPU side).
- R9: `ram_cs_n` is 0 exactly when `vid_turn` is 1 or `ram_sel_n` is 0.
- R10: `ram_we_n` is 0 exactly when `vid_turn` is 0, `ram_sel_n` is 0 and `rw` is 0.
- R11: A RAM access whose strobes first become valid in any slot and are held until acknowledged gets its first acknowledge in slot 2. If it is then held one more clock, it is still acknowledged in slot 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | CPU address strobe, active low |
| uds_n | input | 1 | CPU upper data strobe, active low |
| lds_n | input | 1 | CPU lower data strobe, active low |
| rw | input | 1 | CPU read/write, 1 = read |
| ram_sel_n | input | 1 | External decode: CPU address is in RAM, active low |
| cpu_addr | input | ADDR_W | CPU word address |
| vid_addr | input | ADDR_W | Video fetch address |
| ram_addr | output | ADDR_W | Address presented to the RAM |
| ram_cs_n | output | 1 | RAM chip select, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| xcvr_en_n | output | 1 | CPU data transceiver enable, active low |
| xcvr_dir | output | 1 | Transceiver direction, 1 = RAM to CPU |
| vid_turn | output | 1 | Turn bit, 1 = video owns the RAM |
| dtack_n | output | 1 | Data acknowledge to the CPU, active low |

## Verification
The hardest case to reach is the slot-3 history rule. It needs a RAM access whose strobes appear exactly at slot 3 with nothing acknowledged at slot 2, and another that is held straight through from slot 2. The ports do not show the counter, so the bench tracks the slot from reset. A directed phase sweep then launches a held RAM access at each of the eight slot positions and measures where the first acknowledge lands. Long random traffic is also compared clock by clock against a behavioural model, which covers strobes that toggle around slot 3.

// File: rtl/tsram_pkg.sv
`timescale 1ns/1ps
package tsram_pkg;
  // direction of the CPU data transceiver
  typedef enum logic {
    XDIR_TO_RAM = 1'b0,
    XDIR_TO_CPU = 1'b1
  } xdir_e;

  // decoded CPU bus request for the current clock
  typedef struct packed {
    logic valid;   // strobes form a real access
    logic to_ram;  // decode says the RAM is the target
    logic rd;      // 1 = read
  } cpu_req_t;

  // slot in the CPU half at which the acknowledge opens
  function automatic int unsigned ack_open_slot(input int unsigned cnt_w);
    return (1 << (cnt_w - 1)) - 2;
  endfunction
endpackage

// File: rtl/tsram_slot_counter.sv
`timescale 1ns/1ps
module tsram_slot_counter #(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  output logic [CNT_W-1:0] slot,
  output logic             turn
);
  logic [CNT_W-1:0] slot_q;

  always_ff @(posedge clk) begin
    if (rst) slot_q <= '0;
    else     slot_q <= slot_q + 1'b1;
  end

  assign slot = slot_q;
  assign turn = slot_q[CNT_W-1];
endmodule

// File: rtl/tsram_bus_decode.sv
`timescale 1ns/1ps
module tsram_bus_decode
  import tsram_pkg::*;
(
  input  logic     as_n,
  input  logic     uds_n,
  input  logic     lds_n,
  input  logic     rw,
  input  logic     ram_sel_n,
  output cpu_req_t req
);
  always_comb begin
    req.valid  = ~as_n & (~uds_n | ~lds_n);
    req.to_ram = ~ram_sel_n;
    req.rd     = rw;
  end
endmodule

// File: rtl/tsram_ack_gen.sv
`timescale 1ns/1ps
module tsram_ack_gen
  import tsram_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] slot,
  input  cpu_req_t         req,
  output logic             dtack_n
);
  localparam int unsigned OPEN_I = ack_open_slot(CNT_W);
  localparam logic [CNT_W-1:0] OPEN_SLOT = CNT_W'(OPEN_I);
  localparam logic [CNT_W-1:0] HOLD_SLOT = CNT_W'(OPEN_I + 1);

  logic ack_prev_q;
  logic ram_gate;
  logic ack;

  // RAM window: open slot always, hold slot only as a continuation
  always_comb begin
    ram_gate = 1'b0;
    if (slot == OPEN_SLOT)      ram_gate = 1'b1;
    else if (slot == HOLD_SLOT) ram_gate = ack_prev_q;
  end

  assign ack     = req.valid & (~req.to_ram | ram_gate);
  assign dtack_n = ~ack;

  always_ff @(posedge clk) begin
    if (rst) ack_prev_q <= 1'b0;
    else     ack_prev_q <= ack;
  end
endmodule

// File: rtl/tsram_ram_steer.sv
`timescale 1ns/1ps
module tsram_ram_steer
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              turn,
  input  cpu_req_t          req,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              xcvr_en_n,
  output xdir_e             xcvr_dir
);
  logic cpu_owns;

  assign cpu_owns  = ~turn & req.to_ram;
  assign ram_addr  = turn ? vid_addr : cpu_addr;
  assign ram_cs_n  = ~(turn | req.to_ram);
  assign ram_we_n  = ~(cpu_owns & ~req.rd);
  assign xcvr_en_n = ~cpu_owns;
  assign xcvr_dir  = req.rd ? XDIR_TO_CPU : XDIR_TO_RAM;
endmodule

// File: rtl/tsram_arbiter.sv
`timescale 1ns/1ps
module tsram_arbiter
  import tsram_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic              uds_n,
  input  logic              lds_n,
  input  logic              rw,
  input  logic              ram_sel_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [ADDR_W-1:0] vid_addr,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_cs_n,
  output logic              ram_we_n,
  output logic              xcvr_en_n,
  output logic              xcvr_dir,
  output logic              vid_turn,
  output logic              dtack_n
);
  logic [CNT_W-1:0] slot;
  cpu_req_t         req;
  xdir_e            dir;

  tsram_slot_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk (clk), .rst (rst), .slot (slot), .turn (vid_turn)
  );

  tsram_bus_decode u_dec (
    .as_n (as_n), .uds_n (uds_n), .lds_n (lds_n),
    .rw (rw), .ram_sel_n (ram_sel_n), .req (req)
  );

  tsram_ack_gen #(.CNT_W(CNT_W)) u_ack (
    .clk (clk), .rst (rst), .slot (slot), .req (req), .dtack_n (dtack_n)
  );

  tsram_ram_steer #(.ADDR_W(ADDR_W)) u_steer (
    .turn (vid_turn), .req (req), .cpu_addr (cpu_addr), .vid_addr (vid_addr),
    .ram_addr (ram_addr), .ram_cs_n (ram_cs_n), .ram_we_n (ram_we_n),
    .xcvr_en_n (xcvr_en_n), .xcvr_dir (dir)
  );

  assign xcvr_dir = dir;
endmodule

// File: rtl/tsram_arbiter_chk.sv
`timescale 1ns/1ps
module tsram_arbiter_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             as_n,
  input logic             uds_n,
  input logic             lds_n,
  input logic             rw,
  input logic             ram_sel_n,
  input logic [CNT_W-1:0] slot,
  input logic             vid_turn,
  input logic             ram_cs_n,
  input logic             ram_we_n,
  input logic             xcvr_en_n,
  input logic             dtack_n
);
  localparam logic [CNT_W-1:0] S_OPEN = CNT_W'((1 << (CNT_W - 1)) - 2);
  localparam logic [CNT_W-1:0] S_HOLD = CNT_W'((1 << (CNT_W - 1)) - 1);

  logic strobes_ok;
  assign strobes_ok = !as_n && (!uds_n || !lds_n);

  p_slot_step_r1: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot == $past(slot) + 1'b1));

  p_nonram_follow_r3: assert property (@(posedge clk) disable iff (rst)
    ram_sel_n |-> (dtack_n == !strobes_ok));

  p_open_slot_ack_r4: assert property (@(posedge clk) disable iff (rst)
    (strobes_ok && !ram_sel_n && slot == S_OPEN) |-> !dtack_n);

  p_hold_needs_history_r5: assert property (@(posedge clk) disable iff (rst)
    (slot == S_OPEN && dtack_n) |=> (slot == S_HOLD && !ram_sel_n) |-> dtack_n);

  p_ram_shut_r6: assert property (@(posedge clk) disable iff (rst)
    (!ram_sel_n && slot != S_OPEN && slot != S_HOLD) |-> dtack_n);

  p_idle_no_ack_r7: assert property (@(posedge clk) disable iff (rst)
    !strobes_ok |-> dtack_n);

  p_xcvr_cpu_only_r8: assert property (@(posedge clk) disable iff (rst)
    !xcvr_en_n |-> (!vid_turn && !ram_sel_n));

  p_video_selects_r9: assert property (@(posedge clk) disable iff (rst)
    vid_turn |-> !ram_cs_n);

  p_write_gate_r10: assert property (@(posedge clk) disable iff (rst)
    !ram_we_n |-> (!vid_turn && !ram_sel_n && !rw));
endmodule

bind tsram_arbiter tsram_arbiter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk (clk), .rst (rst), .as_n (as_n), .uds_n (uds_n), .lds_n (lds_n),
  .rw (rw), .ram_sel_n (ram_sel_n), .slot (slot), .vid_turn (vid_turn),
  .ram_cs_n (ram_cs_n), .ram_we_n (ram_we_n), .xcvr_en_n (xcvr_en_n),
  .dtack_n (dtack_n)
);

// File: tb/tsram_arbiter_tb.sv
`timescale 1ns/1ps
module tsram_arbiter_tb;
  localparam int AW = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, ram_sel_n = 1'b1;
  logic [AW-1:0] cpu_addr = '0, vid_addr = '0;
  logic [AW-1:0] ram_addr;
  logic ram_cs_n, ram_we_n, xcvr_en_n, xcvr_dir, vid_turn, dtack_n;

  int checks = 0;
  int errors = 0;
  int mslot = 0;     // reference slot
  bit mprev = 0;     // reference: acknowledge given last clock
  bit started = 0;

  always #2.5 clk = ~clk;

  tsram_arbiter #(.ADDR_W(AW), .CNT_W(3)) u_dut (
    .clk (clk), .rst (rst), .as_n (as_n), .uds_n (uds_n), .lds_n (lds_n),
    .rw (rw), .ram_sel_n (ram_sel_n), .cpu_addr (cpu_addr), .vid_addr (vid_addr),
    .ram_addr (ram_addr), .ram_cs_n (ram_cs_n), .ram_we_n (ram_we_n),
    .xcvr_en_n (xcvr_en_n), .xcvr_dir (xcvr_dir), .vid_turn (vid_turn),
    .dtack_n (dtack_n)
  );

  function automatic bit exp_ack();
    bit v;
    v = !as_n && (!uds_n || !lds_n);
    if (!v) return 0;
    if (ram_sel_n) return 1;
    if (mslot == 2) return 1;
    if (mslot == 3) return mprev;
    return 0;
  endfunction

  task automatic chk(input string req, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s slot=%0d actual=%0h expected=%0h", req, mslot, act, exp);
    end
  endtask

  // reference model state update
  always @(posedge clk) begin
    if (rst) begin
      mslot = 0; mprev = 0; started = 1;
    end else begin
      mprev = exp_ack();
      mslot = (mslot + 1) % 8;
    end
  end

  // clock-by-clock comparison
  always @(negedge clk) begin
    if (started && !rst) begin
      bit t, ram;
      t = (mslot >= 4);
      ram = !ram_sel_n;
      chk("R1 turn", vid_turn, t);
      chk("R2 addr", ram_addr, t ? vid_addr : cpu_addr);
      chk(ram ? "R4/R5/R6/R7 dtack" : "R3/R7 dtack", dtack_n, !exp_ack());
      chk("R8 xcvr_en", xcvr_en_n, !(!t && ram));
      chk("R8 xcvr_dir", xcvr_dir, rw);
      chk("R9 cs", ram_cs_n, !(t || ram));
      chk("R10 we", ram_we_n, !(!t && ram && !rw));
    end
  end

  task automatic idle_bus();
    as_n = 1; uds_n = 1; lds_n = 1; rw = 1; ram_sel_n = 1;
  endtask

  // R11: launch a held RAM access at a given slot
  task automatic phase_run(input int start, input bit wr);
    int waited;
    bit got;
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      if (mslot == start) break;
    end
    as_n = 0; uds_n = 0; lds_n = wr; rw = !wr; ram_sel_n = 0;
    cpu_addr = AW'(16'h1000 + start);
    waited = 0; got = 0;
    for (int k = 0; k < 12 && !got; k++) begin
      @(negedge clk);
      if (!dtack_n) got = 1;
      else begin @(posedge clk); #1; waited++; end
    end
    chk("R11 acked", got, 1);
    chk("R11 first ack slot", mslot, 2);
    chk("R11 wait", waited, (2 - start + 8) % 8);
    @(posedge clk); #1;
    @(negedge clk);
    chk("R11 hold slot3 ack", dtack_n, 0);
    @(posedge clk); #1;
    idle_bus();
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vid_addr = 16'hBEEF; cpu_addr = 16'h0123;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    // R1 reset state: first four slots belong to CPU
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      chk("R1 post-reset turn", vid_turn, k >= 4);
    end
    // R3 non-RAM access acknowledged in every slot
    @(posedge clk); #1;
    as_n = 0; lds_n = 0; ram_sel_n = 1;
    repeat (8) begin
      @(negedge clk); chk("R3 nonram ack", dtack_n, 0);
    end
    @(posedge clk); #1; idle_bus();
    // R7 strobe without data strobe: no ack
    as_n = 0;
    repeat (8) begin
      @(negedge clk); chk("R7 as only", dtack_n, 1);
    end
    @(posedge clk); #1; idle_bus();
    // R5: strobes appear at slot 3 after nothing at slot 2
    for (int k = 0; k < 16; k++) begin
      @(posedge clk); #1;
      if (mslot == 3) break;
    end
    as_n = 0; uds_n = 0; ram_sel_n = 0;
    @(negedge clk); chk("R5 late start no ack", dtack_n, 1);
    @(posedge clk); #1; idle_bus();
    // R11 sweep of start slots, reads and writes
    for (int s = 0; s < 8; s++) phase_run(s, s[0]);
    // random traffic, compared by the model each clock
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk); #1;
      as_n = $urandom_range(0, 3) == 0;
      uds_n = $urandom_range(0, 1) == 1;
      lds_n = $urandom_range(0, 1) == 1;
      rw = $urandom_range(0, 1) == 1;
      ram_sel_n = $urandom_range(0, 2) == 0;
      cpu_addr = AW'($urandom);
      vid_addr = AW'($urandom);
    end
    // reset mid-run returns slot to 0 (R1)
    @(posedge clk); #1; idle_bus(); rst = 1;
    @(posedge clk); #1; rst = 0;
    @(negedge clk); chk("R1 re-reset turn", vid_turn, 0);
    repeat (4) @(posedge clk);
    #1;
    @(negedge clk); chk("R1 slot4 turn", vid_turn, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule